// File: doc/BRIEF.md
# Two-Channel DMA Mode and Trigger Controller

This block is the control front end of a two-channel DMA engine that moves data between a peripheral register space and internal RAM. Each channel has a mode register and a control register. The mode register selects the direction, the element size, a hold control and a hardware start source, and it carries a write-only software trigger. The control register holds an enable bit and a read-only active flag. Each channel also has a transfer count, a source address and a destination address.

Start events are single-cycle hardware request lines or software trigger writes. The block turns them into single transfer requests. A request can be parked while hold is set. The two channels share one bus-request port under fixed priority. Every accepted request becomes one bus cycle that carries the direction, the size and both addresses. The cycle stays up until the done acknowledge returns. The acknowledge then advances the addresses and lowers the count. When the count runs out, the channel leaves the active state.

Top module: `dmx_ctrl`

## Requirements
- R1: After reset, every register of both channels reads 0 and `bus_req` is low. The register selects on `cfg_addr` are: 0 mode, 1 control, 2 count, 3 source address, 4 destination address.
- R2: A write to the mode register with bit 7 = 1 queues exactly one transfer, but only when the channel's enable (control bit 0) and active (control bit 1) flags are both 1. This holds whatever the start-select field (mode bits 3:0) contains, and bit 7 always reads back 0.
- R3: While a channel is active, a cycle in which `hw_req[sel]` is 1 queues one transfer, where sel is mode bits 3:0. A pulse on any other line has no effect.
- R4: `bus_dir` equals mode bit 6 (0: peripheral space to RAM, 1: RAM to peripheral space) and `bus_wide` equals mode bit 5 (0: 8-bit, 1: 16-bit). `bus_req` stays high with stable attributes until `bus_done` is sampled high, and it is low in the following cycle.
- R5: Each acknowledge adds 1 (8-bit) or 2 (16-bit) to that channel's source and destination addresses and lowers its count by 1. When the count reaches 0, control bit 1 clears.
- R6: Writing control bit 0 = 1 sets the active flag if the count is nonzero. Writing it as 0 clears the active flag and discards any queued request.
- R7: With mode bit 4 = 1, queued requests are held and not issued. The hold applies only from the second clock edge after the edge that wrote the bit, so a request that lands on the first edge is still issued.
- R8: Clearing mode bit 4 releases the held request. `bus_req` rises after the second clock edge that follows the clearing write, provided the bus is idle.
- R9: While a channel is active, writes to mode bits 6, 5 and 3:0 are ignored, and so are writes to its count and address registers. Mode bits 7 and 4 keep working.
- R10: With `cfg_bit` = 1, a write to the mode or control register changes only bit `cfg_bitsel` to `cfg_wdata[0]`.
- R11: When both channels have a request pending and the bus is free, channel 0 is served first. Each channel remembers at most one queued request, and extra start events while one is queued are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_bit | input | 1 | Single-bit write select |
| cfg_ch | input | 1 | Channel index for access |
| cfg_addr | input | 3 | Register select |
| cfg_bitsel | input | 3 | Bit position for single-bit writes |
| cfg_wdata | input | 16 | Write data |
| cfg_rdata | output | 16 | Read data of the selected register |
| hw_req | input | 16 | Hardware start request lines |
| bus_req | output | 1 | Transfer request |
| bus_ch | output | 1 | Channel of the current transfer |
| bus_dir | output | 1 | Transfer direction |
| bus_wide | output | 1 | Transfer size is 16 bits |
| bus_src | output | 16 | Source address |
| bus_dst | output | 16 | Destination address |
| bus_done | input | 1 | Transfer acknowledge |

## Verification
Most internal faults in this block appear at the bus port within one or two cycles. A lost or duplicated queued request gives a missing or extra rising edge on `bus_req`. A wrong hold age moves that edge by a cycle. A wrong address step gives a wrong `bus_src` on the next transfer. A lock or count fault is visible through `cfg_rdata` as soon as the register is selected. Because the bench compares both the bus outputs and the selected read value against its model on every cycle, a deviation is caught in the cycle where it first reaches a port.

// File: rtl/dmx_pkg.sv
package dmx_pkg;
    typedef enum logic [2:0] {
        RG_MODE = 3'd0,
        RG_CTRL = 3'd1,
        RG_CNT  = 3'd2,
        RG_SRC  = 3'd3,
        RG_DST  = 3'd4
    } reg_sel_e;

    // mode byte bit positions
    localparam int unsigned MB_TRIG = 7;
    localparam int unsigned MB_DIR  = 6;
    localparam int unsigned MB_WIDE = 5;
    localparam int unsigned MB_HOLD = 4;
endpackage

// File: rtl/dmx_chan.sv
module dmx_chan #(
    parameter int unsigned SEL_W  = 4,
    parameter int unsigned CNT_W  = 10,
    parameter int unsigned ADDR_W = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  dmx_pkg::reg_sel_e         wr_reg,
    input  logic                      wr_bit,
    input  logic [2:0]                wr_pos,
    input  logic [ADDR_W-1:0]         wr_data,
    input  logic [(1<<SEL_W)-1:0]     hw_req,
    input  logic                      grant,
    input  logic                      done,
    output logic                      pend,
    output logic                      dir,
    output logic                      wide,
    output logic                      act,
    output logic [ADDR_W-1:0]         src,
    output logic [ADDR_W-1:0]         dst,
    output logic [CNT_W-1:0]          cnt,
    output logic [7:0]                mode_rd,
    output logic [7:0]                ctrl_rd
);
    import dmx_pkg::*;

    typedef struct packed {
        logic              dir;
        logic              wide;
        logic              hold;
        logic [SEL_W-1:0]  sel;
        logic              en;
        logic              act;
        logic              req;
        logic [1:0]        hage;
        logic [CNT_W-1:0]  cnt;
        logic [ADDR_W-1:0] src;
        logic [ADDR_W-1:0] dst;
    } chan_st_t;

    chan_st_t          s_q, s_d;
    logic [7:0]        cur_byte, wbyte;
    logic              held, sw_hit, hw_hit;
    logic [ADDR_W-1:0] step;

    always_comb begin
        mode_rd  = {1'b0, s_q.dir, s_q.wide, s_q.hold, 4'(s_q.sel)};
        ctrl_rd  = {6'b0, s_q.act, s_q.en};
        cur_byte = (wr_reg == RG_CTRL) ? ctrl_rd : mode_rd;
        wbyte    = wr_data[7:0];
        if (wr_bit) begin
            wbyte         = cur_byte;
            wbyte[wr_pos] = wr_data[0];
        end
        held   = s_q.hold & (&s_q.hage);
        pend   = s_q.req & s_q.act & ~held;
        sw_hit = wr_en && (wr_reg == RG_MODE) && wbyte[MB_TRIG] && s_q.en && s_q.act;
        hw_hit = s_q.act && hw_req[s_q.sel];
        step   = s_q.wide ? ADDR_W'(2) : ADDR_W'(1);

        s_d      = s_q;
        s_d.hage = {s_q.hage[0], s_q.hold};
        if (grant)           s_d.req = 1'b0;
        if (sw_hit || hw_hit) s_d.req = 1'b1;
        if (done) begin
            s_d.src = s_q.src + step;
            s_d.dst = s_q.dst + step;
            s_d.cnt = s_q.cnt - 1'b1;
            if (s_q.cnt == CNT_W'(1)) s_d.act = 1'b0;
        end
        if (wr_en) begin
            case (wr_reg)
                RG_MODE: begin
                    s_d.hold = wbyte[MB_HOLD];
                    if (!s_q.act) begin
                        s_d.dir  = wbyte[MB_DIR];
                        s_d.wide = wbyte[MB_WIDE];
                        s_d.sel  = wbyte[SEL_W-1:0];
                    end
                end
                RG_CTRL: begin
                    s_d.en  = wbyte[0];
                    s_d.act = wbyte[0] && (s_d.cnt != '0);
                end
                RG_CNT: if (!s_q.act) s_d.cnt = wr_data[CNT_W-1:0];
                RG_SRC: if (!s_q.act) s_d.src = wr_data;
                RG_DST: if (!s_q.act) s_d.dst = wr_data;
                default: ;
            endcase
        end
        if (!s_d.act) s_d.req = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign dir  = s_q.dir;
    assign wide = s_q.wide;
    assign act  = s_q.act;
    assign src  = s_q.src;
    assign dst  = s_q.dst;
    assign cnt  = s_q.cnt;
endmodule

// File: rtl/dmx_arb.sv
module dmx_arb #(
    parameter int unsigned NCH    = 2,
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned CH_W   = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCH-1:0]    pend,
    input  logic [NCH-1:0]    dir_v,
    input  logic [NCH-1:0]    wide_v,
    input  logic [ADDR_W-1:0] src_v [NCH],
    input  logic [ADDR_W-1:0] dst_v [NCH],
    input  logic              bus_done,
    output logic [NCH-1:0]    grant,
    output logic              bus_req,
    output logic [CH_W-1:0]   bus_ch,
    output logic              bus_dir,
    output logic              bus_wide,
    output logic [ADDR_W-1:0] bus_src,
    output logic [ADDR_W-1:0] bus_dst
);
    typedef struct packed {
        logic              busy;
        logic [CH_W-1:0]   ch;
        logic              dir;
        logic              wide;
        logic [ADDR_W-1:0] src;
        logic [ADDR_W-1:0] dst;
    } arb_st_t;

    arb_st_t         s_q, s_d;
    logic            found;
    logic [CH_W-1:0] pick;

    always_comb begin
        s_d   = s_q;
        grant = '0;
        found = 1'b0;
        pick  = '0;
        for (int i = 0; i < NCH; i++) begin
            if (pend[i] && !found) begin
                found = 1'b1;
                pick  = CH_W'(i);
            end
        end
        if (s_q.busy) begin
            if (bus_done) s_d.busy = 1'b0;
        end else if (found) begin
            grant[pick] = 1'b1;
            s_d.busy    = 1'b1;
            s_d.ch      = pick;
            s_d.dir     = dir_v[pick];
            s_d.wide    = wide_v[pick];
            s_d.src     = src_v[pick];
            s_d.dst     = dst_v[pick];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign bus_req  = s_q.busy;
    assign bus_ch   = s_q.ch;
    assign bus_dir  = s_q.dir;
    assign bus_wide = s_q.wide;
    assign bus_src  = s_q.src;
    assign bus_dst  = s_q.dst;
endmodule

// File: rtl/dmx_ctrl.sv
module dmx_ctrl #(
    parameter int unsigned NCH    = 2,
    parameter int unsigned SEL_W  = 4,
    parameter int unsigned CNT_W  = 10,
    parameter int unsigned ADDR_W = 16,
    localparam int unsigned NSRC  = 1 << SEL_W,
    localparam int unsigned CH_W  = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic              cfg_bit,
    input  logic [CH_W-1:0]   cfg_ch,
    input  logic [2:0]        cfg_addr,
    input  logic [2:0]        cfg_bitsel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    output logic [ADDR_W-1:0] cfg_rdata,
    input  logic [NSRC-1:0]   hw_req,
    output logic              bus_req,
    output logic [CH_W-1:0]   bus_ch,
    output logic              bus_dir,
    output logic              bus_wide,
    output logic [ADDR_W-1:0] bus_src,
    output logic [ADDR_W-1:0] bus_dst,
    input  logic              bus_done
);
    import dmx_pkg::*;

    reg_sel_e          sel_reg;
    logic [NCH-1:0]    pend_v, dir_v, wide_v, act_v, grant_v, done_v;
    logic [ADDR_W-1:0] src_v [NCH];
    logic [ADDR_W-1:0] dst_v [NCH];
    logic [CNT_W-1:0]  cnt_v [NCH];
    logic [7:0]        mode_v [NCH];
    logic [7:0]        ctrl_v [NCH];

    assign sel_reg = reg_sel_e'(cfg_addr);

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        assign done_v[g] = bus_req & bus_done & (bus_ch == CH_W'(g));
        dmx_chan #(.SEL_W(SEL_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (cfg_wr && (cfg_ch == CH_W'(g))),
            .wr_reg  (sel_reg),
            .wr_bit  (cfg_bit),
            .wr_pos  (cfg_bitsel),
            .wr_data (cfg_wdata),
            .hw_req  (hw_req),
            .grant   (grant_v[g]),
            .done    (done_v[g]),
            .pend    (pend_v[g]),
            .dir     (dir_v[g]),
            .wide    (wide_v[g]),
            .act     (act_v[g]),
            .src     (src_v[g]),
            .dst     (dst_v[g]),
            .cnt     (cnt_v[g]),
            .mode_rd (mode_v[g]),
            .ctrl_rd (ctrl_v[g])
        );
    end

    dmx_arb #(.NCH(NCH), .ADDR_W(ADDR_W), .CH_W(CH_W)) u_arb (
        .clk      (clk),
        .rst_n    (rst_n),
        .pend     (pend_v),
        .dir_v    (dir_v),
        .wide_v   (wide_v),
        .src_v    (src_v),
        .dst_v    (dst_v),
        .bus_done (bus_done),
        .grant    (grant_v),
        .bus_req  (bus_req),
        .bus_ch   (bus_ch),
        .bus_dir  (bus_dir),
        .bus_wide (bus_wide),
        .bus_src  (bus_src),
        .bus_dst  (bus_dst)
    );

    always_comb begin
        case (sel_reg)
            RG_MODE: cfg_rdata = ADDR_W'(mode_v[cfg_ch]);
            RG_CTRL: cfg_rdata = ADDR_W'(ctrl_v[cfg_ch]);
            RG_CNT:  cfg_rdata = ADDR_W'(cnt_v[cfg_ch]);
            RG_SRC:  cfg_rdata = src_v[cfg_ch];
            RG_DST:  cfg_rdata = dst_v[cfg_ch];
            default: cfg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/dmx_chk.sv
module dmx_chk #(
    parameter int unsigned NCH    = 2,
    parameter int unsigned CNT_W  = 10,
    parameter int unsigned ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_req,
    input logic              bus_done,
    input logic              bus_dir,
    input logic              bus_wide,
    input logic [ADDR_W-1:0] bus_src,
    input logic [ADDR_W-1:0] bus_dst,
    input logic [NCH-1:0]    act_v,
    input logic [NCH-1:0]    done_v,
    input logic [CNT_W-1:0]  cnt_v [NCH]
);
    AST_BUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_done |=> bus_req && $stable(bus_dir) && $stable(bus_wide)
                                 && $stable(bus_src) && $stable(bus_dst)); // R4
    AST_DONE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_done |=> !bus_req); // R4

    for (genvar g = 0; g < NCH; g++) begin : g_chk
        AST_LAST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
            done_v[g] && (cnt_v[g] == CNT_W'(1)) |=> !act_v[g]); // R5
        AST_CNT_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
            act_v[g] && !done_v[g] |=> $stable(cnt_v[g])); // R9
    end
endmodule

bind dmx_ctrl dmx_chk #(.NCH(NCH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_req  (bus_req),
    .bus_done (bus_done),
    .bus_dir  (bus_dir),
    .bus_wide (bus_wide),
    .bus_src  (bus_src),
    .bus_dst  (bus_dst),
    .act_v    (act_v),
    .done_v   (done_v),
    .cnt_v    (cnt_v)
);

// File: tb/sim_dmx_ctrl.sv
`timescale 1ns/1ps
module sim_dmx_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0, cfg_bit = 1'b0;
    logic [0:0]  cfg_ch = '0;
    logic [2:0]  cfg_addr = '0, cfg_bitsel = '0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic [15:0] hw_req = '0;
    logic        bus_req, bus_dir, bus_wide;
    logic [0:0]  bus_ch;
    logic [15:0] bus_src, bus_dst;
    logic        bus_done = 1'b0;

    int checks = 0, fails = 0, cyc = 0, resp_lat = 2, wait_ct = 0;
    bit prev_req = 0;
    int q[$];

    always #2.5 clk = ~clk;

    dmx_ctrl u0 (.*);

    // behavioural reference model
    bit m_dir[2], m_wide[2], m_hold[2], m_en[2], m_act[2], m_req[2], oact[2], ev[2];
    int m_age[2], m_sel[2], m_cnt[2], m_src[2], m_dst[2];
    int m_busy = 0, m_bch = 0, m_bdir = 0, m_bwide = 0, m_bsrc = 0, m_bdst = 0;
    int g_pick, d_ch, wb;

    function automatic int m_mode(int c);
        return (int'(m_dir[c]) << 6) | (int'(m_wide[c]) << 5) | (int'(m_hold[c]) << 4) | m_sel[c];
    endfunction
    function automatic int m_rd(int c, int a);
        case (a)
            0: return m_mode(c);
            1: return (int'(m_act[c]) << 1) | int'(m_en[c]);
            2: return m_cnt[c];
            3: return m_src[c];
            4: return m_dst[c];
            default: return 0;
        endcase
    endfunction
    function automatic int m_wbyte(int c);
        int cur;
        if (!cfg_bit) return int'(cfg_wdata) & 255;
        cur = (cfg_addr == 3'd1) ? m_rd(c, 1) : m_mode(c);
        if (cfg_wdata[0]) cur = cur | (1 << cfg_bitsel);
        else              cur = cur & ~(1 << cfg_bitsel);
        return cur;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < 2; c++) begin
                m_dir[c] = 0; m_wide[c] = 0; m_hold[c] = 0; m_en[c] = 0; m_act[c] = 0;
                m_req[c] = 0; m_age[c] = 0; m_sel[c] = 0; m_cnt[c] = 0; m_src[c] = 0; m_dst[c] = 0;
            end
            m_busy = 0;
        end else begin
            g_pick = -1; d_ch = -1;
            wb = m_wbyte(int'(cfg_ch));
            for (int c = 0; c < 2; c++) begin
                oact[c] = m_act[c];
                ev[c] = m_act[c] && (hw_req[m_sel[c]] || (cfg_wr && int'(cfg_ch) == c &&
                        cfg_addr == 3'd0 && ((wb >> 7) & 1) == 1 && m_en[c]));
            end
            if (m_busy != 0) begin
                if (bus_done) begin d_ch = m_bch; m_busy = 0; end
            end else begin
                for (int c = 0; c < 2; c++)
                    if (g_pick < 0 && m_req[c] && m_act[c] && !(m_hold[c] && m_age[c] >= 2)) g_pick = c;
            end
            if (g_pick >= 0) begin
                m_busy = 1; m_bch = g_pick; m_bdir = m_dir[g_pick]; m_bwide = m_wide[g_pick];
                m_bsrc = m_src[g_pick]; m_bdst = m_dst[g_pick];
            end
            for (int c = 0; c < 2; c++) begin
                if (m_hold[c] && m_age[c] < 3) m_age[c]++;
                if (g_pick == c) m_req[c] = 0;
                if (ev[c]) m_req[c] = 1;
                if (d_ch == c) begin
                    m_src[c] = (m_src[c] + (m_wide[c] ? 2 : 1)) & 16'hffff;
                    m_dst[c] = (m_dst[c] + (m_wide[c] ? 2 : 1)) & 16'hffff;
                    if (m_cnt[c] == 1) m_act[c] = 0;
                    m_cnt[c] = (m_cnt[c] - 1) & 1023;
                end
                if (cfg_wr && int'(cfg_ch) == c) begin
                    case (int'(cfg_addr))
                        0: begin
                            if (((wb >> 4) & 1) == 1 && !m_hold[c]) m_age[c] = 0;
                            m_hold[c] = ((wb >> 4) & 1) == 1;
                            if (!oact[c]) begin
                                m_dir[c] = ((wb >> 6) & 1) == 1;
                                m_wide[c] = ((wb >> 5) & 1) == 1;
                                m_sel[c] = wb & 15;
                            end
                        end
                        1: begin m_en[c] = (wb & 1) == 1; m_act[c] = m_en[c] && m_cnt[c] != 0; end
                        2: if (!oact[c]) m_cnt[c] = int'(cfg_wdata) & 1023;
                        3: if (!oact[c]) m_src[c] = int'(cfg_wdata);
                        4: if (!oact[c]) m_dst[c] = int'(cfg_wdata);
                        default: ;
                    endcase
                end
                if (!m_act[c]) m_req[c] = 0;
            end
        end
    end

    task automatic chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // per-cycle comparison against the model, plus grant log
    always @(negedge clk) begin
        if (rst_n) begin
            chk(bus_req == (m_busy != 0), "R4 bus_req", int'(bus_req), m_busy);
            if (m_busy != 0) begin
                chk(int'(bus_ch) == m_bch, "R11 bus_ch", int'(bus_ch), m_bch);
                chk(int'(bus_dir) == m_bdir, "R4 bus_dir", int'(bus_dir), m_bdir);
                chk(int'(bus_wide) == m_bwide, "R4 bus_wide", int'(bus_wide), m_bwide);
                chk(int'(bus_src) == m_bsrc, "R5 bus_src", int'(bus_src), m_bsrc);
                chk(int'(bus_dst) == m_bdst, "R5 bus_dst", int'(bus_dst), m_bdst);
            end
            chk(int'(cfg_rdata) == m_rd(int'(cfg_ch), int'(cfg_addr)),
                (cfg_addr == 3'd0) ? "R10 mode read" : (cfg_addr == 3'd1) ? "R6 ctrl read" : "R5 read",
                int'(cfg_rdata), m_rd(int'(cfg_ch), int'(cfg_addr)));
            if (bus_req && !prev_req) q.push_back(int'(bus_ch));
            prev_req = bus_req;
        end
    end

    // acknowledge responder
    initial forever begin
        @(posedge clk); #1;
        if (bus_req && !bus_done) begin
            wait_ct++;
            if (wait_ct >= resp_lat) begin bus_done = 1'b1; wait_ct = 0; end
        end else bus_done = 1'b0;
    end

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            fails++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            finish_run();
        end
    end

    task automatic wr(int c, int a, int d);
        @(posedge clk); #1;
        cfg_wr = 1; cfg_bit = 0; cfg_ch = c[0:0]; cfg_addr = a[2:0]; cfg_wdata = d[15:0];
        @(posedge clk); #1 cfg_wr = 0;
    endtask
    task automatic wrb(int c, int a, int pos, int v);
        @(posedge clk); #1;
        cfg_wr = 1; cfg_bit = 1; cfg_ch = c[0:0]; cfg_addr = a[2:0]; cfg_bitsel = pos[2:0]; cfg_wdata = v[15:0];
        @(posedge clk); #1 begin cfg_wr = 0; cfg_bit = 0; end
    endtask
    task automatic pulse(int m);
        @(posedge clk); #1 hw_req = m[15:0];
        @(posedge clk); #1 hw_req = '0;
    endtask
    task automatic idle(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask
    task automatic rd(int c, int a, int exp, string tag);
        @(posedge clk); #1 begin cfg_ch = c[0:0]; cfg_addr = a[2:0]; end
        @(negedge clk);
        chk(int'(cfg_rdata) == exp, tag, int'(cfg_rdata), exp);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // R1: reset values
        for (int a = 0; a < 5; a++) rd(0, a, 0, "R1 ch0 reset");
        for (int a = 0; a < 5; a++) rd(1, a, 0, "R1 ch1 reset");
        chk(bus_req == 0, "R1 bus_req reset", int'(bus_req), 0);

        // R2: software trigger, one transfer each
        wr(0, 2, 3); wr(0, 3, 'h100); wr(0, 4, 'h200); wr(0, 0, 'h00); wr(0, 1, 1);
        q.delete();
        wr(0, 0, 'h80); idle(8);
        chk(q.size() == 1, "R2 one transfer per trigger", q.size(), 1);
        rd(0, 0, 0, "R2 trigger reads 0");
        wr(0, 0, 'h80); idle(8); wr(0, 0, 'h80); idle(8);
        rd(0, 1, 1, "R5 active clears at count 0");
        rd(0, 3, 'h103, "R5 8-bit source step");

        // R3: hardware start select
        wr(1, 2, 4); wr(1, 3, 'h40); wr(1, 4, 'h80); wr(1, 0, 'h63); wr(1, 1, 1);
        q.delete();
        pulse(1 << 5); idle(6);
        chk(q.size() == 0, "R3 unselected line ignored", q.size(), 0);
        pulse(1 << 3); idle(8);
        chk(q.size() == 1, "R3 selected line starts", q.size(), 1);
        rd(1, 4, 'h82, "R5 16-bit destination step");

        // R9: locked fields while active
        wr(1, 0, 'h00);
        rd(1, 0, 'h63, "R9 mode fields locked");
        wr(1, 2, 7);
        rd(1, 2, 3, "R9 count locked");

        // R7/R10: hold via single-bit write, first-edge request still issues
        q.delete();
        @(posedge clk); #1;
        cfg_wr = 1; cfg_bit = 1; cfg_ch = 1; cfg_addr = 0; cfg_bitsel = 4; cfg_wdata = 1;
        @(posedge clk); #1 begin cfg_wr = 0; cfg_bit = 0; hw_req = 16'h0008; end
        @(posedge clk); #1 hw_req = '0;
        idle(8);
        chk(q.size() == 1, "R7 request before hold takes effect", q.size(), 1);
        rd(1, 0, 'h73, "R10 single-bit write");
        pulse(1 << 3); idle(10);
        chk(q.size() == 1, "R7 request held", q.size(), 1);
        wrb(1, 0, 4, 0); idle(8);
        chk(q.size() == 2, "R8 release issues held request", q.size(), 2);

        // R11: priority and single remembered request
        wr(0, 1, 0); wr(0, 0, 'h02); wr(0, 2, 5); wr(0, 1, 1);
        wr(1, 1, 0); wr(1, 2, 4); wr(1, 1, 1);
        resp_lat = 8; q.delete();
        pulse(12); idle(2); pulse(12); idle(40);
        chk(q.size() == 3, "R11 extra request dropped", q.size(), 3);
        if (q.size() == 3) begin
            chk(q[0] == 0, "R11 channel 0 first", q[0], 0);
            chk(q[1] == 0, "R11 channel 0 again", q[1], 0);
            chk(q[2] == 1, "R11 channel 1 last", q[2], 1);
        end

        // R2: trigger independent of start select, ignored when disabled
        resp_lat = 2; q.delete();
        wr(0, 0, 'h82); idle(8);
        chk(q.size() == 1, "R2 trigger with select 2", q.size(), 1);
        wr(0, 1, 0); q.delete();
        wr(0, 0, 'h80); idle(8);
        chk(q.size() == 0, "R2 trigger ignored when disabled", q.size(), 0);

        // R6: disable drops held request
        q.delete();
        wrb(1, 0, 4, 1); idle(3); pulse(1 << 3); idle(4);
        chk(q.size() == 0, "R7 held before disable", q.size(), 0);
        wr(1, 1, 0);
        rd(1, 1, 0, "R6 disable clears active");
        wrb(1, 0, 4, 0); idle(6); wr(1, 1, 1); idle(8);
        chk(q.size() == 0, "R6 held request discarded", q.size(), 0);
        rd(1, 1, 3, "R6 enable sets active");

        idle(4);
        finish_run();
    end
endmodule